// File: doc/BRIEF.md
# Masked Block-Write Datapath

This block sits in front of a memory column array whose words are 16 bits wide. It captures one request per clock and turns it into write strobes for each column and write enables for each bit. A request carries a 2-bit cycle kind, a column address, a 16-bit data word and two byte-lane enables. Two internal registers shape the writes. The first is a persistent write-mask register, which gates the bits of every later write until it is loaded again. The second is a color register, which supplies the word used by fill writes.

A plain write stores the data word in one column. A block write stores the color word, in a single cycle, into any subset of a group of `COLS` adjacent columns, where `COLS` is 4 or 8. The data bus picks the subset, and the group starts at the column address with its low log2(`COLS`) bits cleared. Load cycles update the mask or the color register one byte lane at a time. The memory array itself is outside the block: it applies `wr_data` to column `wr_base + i` wherever `wr_strobe[i]` is set, and only on the bits set in `wr_bit_en`.

Top module: `mbw_top`

## Requirements
- R1: After reset the mask register is all ones and the color register is zero. The first write after reset therefore enables every bit allowed by its lanes, and the first block write stores zero.
- R2: A request with `req_valid` high and kind 2'b00 (write) produces exactly one strobe, at index `req_col[S-1:0]` where S = log2(`COLS`). It also sets `wr_base` to `req_col` with its low S bits cleared and sets `wr_data` to the request data.
- R3: Kind 2'b01 (block write) sets `wr_strobe[i]` to `req_data[i]` for i below `COLS` and sets `wr_data` to the color register. `wr_base` is aligned as in R2. Data bits at `COLS` and above select nothing.
- R4: Kind 2'b10 (load mask) copies the request data into the mask register, on lane 0 (bits 7:0) only if `lane_lo_en` is set and on lane 1 (bits 15:8) only if `lane_hi_en` is set. It raises no strobe and no bit enable.
- R5: Kind 2'b11 (load color) updates the color register with the same lane rule as R4. It raises no strobe and no bit enable.
- R6: The mask register keeps its value through any number of write and block-write cycles.
- R7: On both writes and block writes, `wr_bit_en` equals the mask register ANDed with the lane enables, each lane enable covering 8 bits. With both lanes off, every bit enable is zero while the strobes still appear.
- R8: The outputs for a request are the values captured at the clock edge that accepted it. They stay the same when the request inputs change during the following cycle.
- R9: A cycle with `req_valid` low drives all outputs to zero and leaves both registers unchanged, whatever kind, address and data accompany it.
- R10: When `COLS` is 8, the strobe vector is 8 wide, the low 3 address bits select the column of a write, and the base clears those 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 00 write, 01 block write, 10 load mask, 11 load color |
| req_col | input | COL_AW | Column address |
| req_data | input | 16 | Write data, column-select mask, or register load value |
| lane_lo_en | input | 1 | Enables bits 7:0 |
| lane_hi_en | input | 1 | Enables bits 15:8 |
| wr_strobe | output | COLS | Strobe for column wr_base+i |
| wr_base | output | COL_AW | First column of the aligned group |
| wr_data | output | 16 | Word to store |
| wr_bit_en | output | 16 | Bit write enables |

## Verification
The bench loads a mask that differs between the two lanes and then writes with each lane combination. A design that skipped the lane gate on loads, or left the mask out of block writes, would produce wrong enable patterns. A block write immediately after reset has to store zero, and a block write after a single-lane color load has to store the mixed word, which exposes a color register that resets wrong or ignores the lanes. An idle cycle that carries a load-mask kind with zero data tests whether `req_valid` really gates register updates. A write to the top column tests base alignment for both 4 and 8 columns, and a block write whose select bits sit only above `COLS` tests that it raises no strobe. Every request input changes half a nanosecond after the accepting edge, so a design that does not hold its captured request fails on every sample.

// File: rtl/mbw_pkg.sv
package mbw_pkg;

    localparam int WORD_W = 16;
    localparam int LANE_W = 8;
    localparam int N_LANES = WORD_W / LANE_W;

    typedef enum logic [1:0] {
        CK_WRITE  = 2'b00,
        CK_BLOCK  = 2'b01,
        CK_LDMASK = 2'b10,
        CK_LDCLR  = 2'b11
    } cyc_kind_e;

    typedef struct packed {
        logic                 valid;
        cyc_kind_e            kind;
        logic [WORD_W-1:0]    data;
        logic [N_LANES-1:0]   lanes;
    } req_t;

    function automatic logic [WORD_W-1:0] lane_bits(input logic [N_LANES-1:0] l);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < N_LANES; i++) begin
            r[i*LANE_W +: LANE_W] = {LANE_W{l[i]}};
        end
        return r;
    endfunction

    function automatic logic is_store(input req_t r);
        return r.valid && (r.kind == CK_WRITE || r.kind == CK_BLOCK);
    endfunction

    function automatic logic is_load(input req_t r);
        return r.valid && (r.kind == CK_LDMASK || r.kind == CK_LDCLR);
    endfunction

endpackage

// File: rtl/mbw_req_latch.sv
module mbw_req_latch
    import mbw_pkg::*;
#(
    parameter int COL_AW = 9
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic [1:0]                   in_kind,
    input  logic [COL_AW-1:0]            in_col,
    input  logic [WORD_W-1:0]            in_data,
    input  logic [N_LANES-1:0]           in_lanes,
    output req_t                         q_req,
    output logic [COL_AW-1:0]            q_col
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_req <= '0;
            q_col <= '0;
        end else begin
            q_req.valid <= in_valid;
            q_req.kind  <= cyc_kind_e'(in_kind);
            q_req.data  <= in_data;
            q_req.lanes <= in_lanes;
            q_col       <= in_col;
        end
    end

    // R8: the captured request reflects the inputs of the previous edge
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (q_req.valid == $past(in_valid) && q_req.data == $past(in_data)));

endmodule

// File: rtl/mbw_regs.sv
module mbw_regs
    import mbw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  req_t               req,
    output logic [WORD_W-1:0]  mask_q,
    output logic [WORD_W-1:0]  color_q
);

    logic [WORD_W-1:0] lane_m;
    logic              ld_mask;
    logic              ld_color;

    always_comb begin
        lane_m   = lane_bits(req.lanes);
        ld_mask  = req.valid && req.kind == CK_LDMASK;
        ld_color = req.valid && req.kind == CK_LDCLR;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            color_q <= '0;
        end else begin
            if (ld_mask)
                mask_q <= (mask_q & ~lane_m) | (req.data & lane_m);
            if (ld_color)
                color_q <= (color_q & ~lane_m) | (req.data & lane_m);
        end
    end

    // R1: reset values
    a_r1_reset_vals: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '1 && color_q == '0));

    // R6, R9: the mask only moves on a load-mask cycle
    a_r6_mask_persist: assert property (@(posedge clk) disable iff (rst)
        !ld_mask |=> $stable(mask_q));

    // R9: the color only moves on a load-color cycle
    a_r9_color_hold: assert property (@(posedge clk) disable iff (rst)
        !ld_color |=> $stable(color_q));

    // R4: a disabled lane of the mask is untouched by a load
    a_r4_lane_lo_hold: assert property (@(posedge clk) disable iff (rst)
        (ld_mask && !req.lanes[0]) |=> $stable(mask_q[LANE_W-1:0]));

    // R5: a disabled upper lane of the color is untouched by a load
    a_r5_lane_hi_hold: assert property (@(posedge clk) disable iff (rst)
        (ld_color && !req.lanes[1]) |=> $stable(color_q[WORD_W-1:LANE_W]));

endmodule

// File: rtl/mbw_strobe_gen.sv
module mbw_strobe_gen
    import mbw_pkg::*;
#(
    parameter int COLS   = 4,
    parameter int COL_AW = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  req_t               req,
    input  logic [COL_AW-1:0]  col,
    output logic [COLS-1:0]    strobe,
    output logic [COL_AW-1:0]  base
);

    localparam int SEL_W = $clog2(COLS);

    logic wr_cyc;
    logic blk_cyc;

    assign wr_cyc  = req.valid && req.kind == CK_WRITE;
    assign blk_cyc = req.valid && req.kind == CK_BLOCK;

    for (genvar i = 0; i < COLS; i++) begin : g_col
        assign strobe[i] = (wr_cyc && col[SEL_W-1:0] == SEL_W'(i)) ||
                           (blk_cyc && req.data[i]);
    end

    assign base = is_store(req) ? {col[COL_AW-1:SEL_W], {SEL_W{1'b0}}} : '0;

    // R2: a plain write hits exactly one column
    a_r2_single_col: assert property (@(posedge clk) disable iff (rst)
        wr_cyc |-> $countones(strobe) == 1);

    // R3: a block write never strobes a column its select bit leaves off
    a_r3_blk_subset: assert property (@(posedge clk) disable iff (rst)
        blk_cyc |-> (strobe & ~req.data[COLS-1:0]) == '0);

endmodule

// File: rtl/mbw_top.sv
module mbw_top
    import mbw_pkg::*;
#(
    parameter int COLS   = 4,
    parameter int COL_AW = 9
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_kind,
    input  logic [COL_AW-1:0]  req_col,
    input  logic [15:0]        req_data,
    input  logic               lane_lo_en,
    input  logic               lane_hi_en,
    output logic [COLS-1:0]    wr_strobe,
    output logic [COL_AW-1:0]  wr_base,
    output logic [15:0]        wr_data,
    output logic [15:0]        wr_bit_en
);

    req_t               cur;
    logic [COL_AW-1:0]  cur_col;
    logic [WORD_W-1:0]  mask_q;
    logic [WORD_W-1:0]  color_q;

    mbw_req_latch #(.COL_AW(COL_AW)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .in_valid (req_valid),
        .in_kind  (req_kind),
        .in_col   (req_col),
        .in_data  (req_data),
        .in_lanes ({lane_hi_en, lane_lo_en}),
        .q_req    (cur),
        .q_col    (cur_col)
    );

    mbw_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (cur),
        .mask_q  (mask_q),
        .color_q (color_q)
    );

    mbw_strobe_gen #(.COLS(COLS), .COL_AW(COL_AW)) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .req    (cur),
        .col    (cur_col),
        .strobe (wr_strobe),
        .base   (wr_base)
    );

    always_comb begin
        wr_data   = '0;
        wr_bit_en = '0;
        if (is_store(cur)) begin
            wr_data   = (cur.kind == CK_BLOCK) ? color_q : cur.data;
            wr_bit_en = mask_q & lane_bits(cur.lanes);
        end
    end

    // R4, R5: load cycles write nothing to the array
    a_r4_load_quiet: assert property (@(posedge clk) disable iff (rst)
        is_load(cur) |-> (wr_strobe == '0 && wr_bit_en == '0));

    // R7: no bit enable outside the enabled lanes
    a_r7_lane_gate: assert property (@(posedge clk) disable iff (rst)
        (wr_bit_en & ~lane_bits(cur.lanes)) == '0);

    // R9: an idle cycle is silent
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cur.valid |-> (wr_strobe == '0 && wr_bit_en == '0 && wr_data == '0));

endmodule

// File: tb/sim_mbw_top.sv
`timescale 1ns/100ps
module sim_mbw_top;

    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic [AW-1:0] req_col = '0;
    logic [15:0]   req_data = '0;
    logic          lane_lo_en = 1'b0;
    logic          lane_hi_en = 1'b0;

    logic [3:0]    s4;
    logic [7:0]    s8;
    logic [AW-1:0] b4, b8;
    logic [15:0]   d4, d8, e4, e8;

    always #2 clk = ~clk;

    mbw_top #(.COLS(4), .COL_AW(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_col(req_col), .req_data(req_data), .lane_lo_en(lane_lo_en),
        .lane_hi_en(lane_hi_en), .wr_strobe(s4), .wr_base(b4),
        .wr_data(d4), .wr_bit_en(e4));

    mbw_top #(.COLS(8), .COL_AW(AW)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_col(req_col), .req_data(req_data), .lane_lo_en(lane_lo_en),
        .lane_hi_en(lane_hi_en), .wr_strobe(s8), .wr_base(b8),
        .wr_data(d8), .wr_bit_en(e8));

    typedef struct {
        int            due;
        logic [3:0]    s4;
        logic [7:0]    s8;
        logic [AW-1:0] b4;
        logic [AW-1:0] b8;
        logic [15:0]   dat;
        logic [15:0]   be;
        string         tag;
    } exp_t;

    exp_t       q[$];
    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    logic [15:0] mask_m = 16'hFFFF;
    logic [15:0] color_m = 16'h0000;

    // monitor: sample 1 ns after each rising edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        #1;
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t x;
            x = q.pop_front();
            checks++;
            if (s4 !== x.s4 || s8 !== x.s8 || b4 !== x.b4 || b8 !== x.b8 ||
                d4 !== x.dat || d8 !== x.dat || e4 !== x.be || e8 !== x.be) begin
                errors++;
                $display("FAIL %s: got s4=%h s8=%h b4=%0d b8=%0d d=%h/%h be=%h/%h exp s4=%h s8=%h b4=%0d b8=%0d d=%h be=%h",
                         x.tag, s4, s8, b4, b8, d4, d8, e4, e8,
                         x.s4, x.s8, x.b4, x.b8, x.dat, x.be);
            end
        end
    end

    task automatic send(input logic v, input logic [1:0] k, input logic [AW-1:0] c,
                        input logic [15:0] d, input logic [1:0] ln, input string tag);
        exp_t x;
        logic [15:0] lm;
        @(posedge clk);
        #0.5;
        req_valid  = v;
        req_kind   = k;
        req_col    = c;
        req_data   = d;
        lane_lo_en = ln[0];
        lane_hi_en = ln[1];
        lm = {{8{ln[1]}}, {8{ln[0]}}};
        x.due = cyc + 1;
        x.tag = tag;
        x.s4 = '0; x.s8 = '0; x.b4 = '0; x.b8 = '0; x.dat = '0; x.be = '0;
        if (v && (k == 2'b00 || k == 2'b01)) begin
            x.b4  = {c[AW-1:2], 2'b00};
            x.b8  = {c[AW-1:3], 3'b000};
            x.be  = mask_m & lm;
            if (k == 2'b00) begin
                x.s4  = 4'(1 << c[1:0]);
                x.s8  = 8'(1 << c[2:0]);
                x.dat = d;
            end else begin
                x.s4  = d[3:0];
                x.s8  = d[7:0];
                x.dat = color_m;
            end
        end
        if (v && k == 2'b10) mask_m  = (mask_m & ~lm) | (d & lm);
        if (v && k == 2'b11) color_m = (color_m & ~lm) | (d & lm);
        q.push_back(x);
    endtask

    initial begin : watchdog
        #100000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        send(0, 2'b00, 9'd0,   16'h0000, 2'b00, "R1 R9 idle after reset");
        send(1, 2'b00, 9'd5,   16'hA5A5, 2'b11, "R1 R2 R8 write reset mask");
        send(1, 2'b01, 9'd13,  16'h00F5, 2'b11, "R1 R3 block reset color");
        send(1, 2'b10, 9'd0,   16'h0F0F, 2'b11, "R4 load mask both lanes");
        send(1, 2'b00, 9'd2,   16'h1234, 2'b11, "R4 R6 write under mask");
        send(1, 2'b11, 9'd0,   16'hBEEF, 2'b01, "R5 load color low lane");
        send(1, 2'b01, 9'd8,   16'h0003, 2'b11, "R3 R5 block after color load");
        send(1, 2'b10, 9'd0,   16'hFFFF, 2'b10, "R4 load mask high lane");
        send(1, 2'b00, 9'd7,   16'h5555, 2'b01, "R7 write low lane");
        send(1, 2'b00, 9'd7,   16'h5555, 2'b10, "R7 write high lane");
        send(1, 2'b00, 9'd6,   16'h5555, 2'b00, "R7 write no lanes");
        send(0, 2'b10, 9'd3,   16'h0000, 2'b11, "R9 idle with load kind");
        send(1, 2'b00, 9'd511, 16'hC3C3, 2'b11, "R6 R9 R10 write top column");
        send(1, 2'b01, 9'd20,  16'hFF00, 2'b11, "R3 R10 block high selects only");
        send(1, 2'b11, 9'd0,   16'h1234, 2'b10, "R5 load color high lane");
        send(1, 2'b11, 9'd0,   16'hFFFF, 2'b00, "R5 load color no lanes");
        send(1, 2'b01, 9'd509, 16'hFFFF, 2'b11, "R3 R10 block all columns");
        send(1, 2'b01, 9'd33,  16'h0012, 2'b01, "R3 R7 block low lane");
        send(0, 2'b00, 9'd0,   16'h0000, 2'b00, "R9 idle");
        @(posedge clk);
        #0.5 rst = 1'b1;
        req_valid = 1'b0;
        @(posedge clk);
        #0.5 rst = 1'b0;
        mask_m  = 16'hFFFF;
        color_m = 16'h0000;
        send(1, 2'b00, 9'd1,   16'h0F0F, 2'b11, "R1 write after second reset");
        send(1, 2'b01, 9'd4,   16'h000F, 2'b11, "R1 block after second reset");
        send(0, 2'b00, 9'd0,   16'h0000, 2'b00, "R9 final idle");
        repeat (3) @(posedge clk);
        if (q.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: got %0d pending exp 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule